// File: doc/BRIEF.md
# Paired Bitslip Word Aligner

This block brings a master deserializer lane and a slave deserializer lane onto a common word boundary. Both lanes receive the same repeating loopback pulse pattern. The block looks at a 10-bit word built from both lanes. The two low bits come from the slave lane and the eight upper bits come from the master lane. It treats the word as five 2-bit pairs. It steers the lanes by sending one-clock bitslip pulses to the deserializers. Two pulses make one adjustment step, which moves the lane's word by one pair.

Alignment has two phases.

- **Joint phase.** Both lanes are stepped together until the slave pair holds a set bit.
- **Master-only phase.** Only the master lane is stepped, until none of the four master pairs repeats the slave pair.

Before every sample the block waits a programmable settling time, so that the deserializer outputs have settled after the previous step. When the word is aligned, the block raises `done`. It also raises `done` once its step budget is used up, so it can never hang. The deserializers themselves are outside the block.

Top module: `pba_aligner`

## Requirements
- R1: While reset is asserted, and after reset until `start` is seen high, `master_slip`, `slave_slip` and `done` are all low.
- R2: Every adjustment step on an output is the four-clock pattern pulse, low, pulse, low, and each pulse lasts exactly one clock.
- R3: In the joint phase, `slave_slip` and `master_slip` pulse in exactly the same clocks.
- R4: In the joint phase, each sample whose bits 1:0 are 00 starts a joint step. A sample with nonzero bits 1:0 ends the joint phase.
- R5: Once the master-only phase has begun, `slave_slip` stays low.
- R6: In the master-only phase, a master step is taken after each sample in which any pair k = 1..4 (bits 2k+1:2k) equals the nonzero bits 1:0. The phase is entered directly from the joint-phase sample that first shows a nonzero slave pair.
- R7: The first sample is taken `STAB_CYCLES` clocks after `start` is accepted. Every step is followed by two idle clocks and then a fresh `STAB_CYCLES` wait before the next sample. A step begins on the clock after the sample that requests it.
- R8: When a sample shows a nonzero slave pair that no master pair duplicates, `done` rises on the next clock and no further bitslip pulse is produced.
- R9: After five joint-phase samples that all have 00 in bits 1:0, `done` is raised without a fifth joint step. After five master steps, a sample that still shows a duplicate raises `done` instead of a sixth master step.
- R10: `done` stays high until reset. While the block is aligning or done, `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins alignment when high in the idle state |
| rx_word | input | 10 | Combined lane word: bits 9:2 from the master lane, bits 1:0 from the slave lane |
| master_slip | output | 1 | One-clock bitslip pulse to the master deserializer |
| slave_slip | output | 1 | One-clock bitslip pulse to the slave deserializer |
| done | output | 1 | Alignment finished (aligned or budget used up) |

## Verification
Two functions can fall in the same sample cycle: the end of the joint phase and the first master-only step decision. This happens when the first sample with a nonzero slave pair also shows that pair repeated in the master lane. The bench provokes it with double-bit and single-bit patterns whose starting lane offsets place a duplicate in the master pairs exactly when the slave pair becomes nonzero, both on the first sample and after several joint steps. The bench emulates the two lanes, rotating each lane's view on every observed pulse. A behavioural reference generates the expected pulse and `done` sequence for every clock. Any clock in which `slave_slip` pulses alongside the first master step counts as a mismatch.

// File: rtl/pba_pkg.sv
package pba_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SLIP = 2'd2,
        ST_DONE = 2'd3
    } pba_state_e;

endpackage

// File: rtl/pba_stab_timer.sv
module pba_stab_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + CNT_W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == CNT_W'(CYCLES - 1));
endmodule

// File: rtl/pba_slip_seq.sv
module pba_slip_seq #(
    parameter int GAP_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse,
    output logic finished
);
    localparam int SEQ_LEN = 4 + GAP_CYCLES;
    localparam int CNT_W   = $clog2(SEQ_LEN + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.active) begin
            if (seq_q.cnt == CNT_W'(SEQ_LEN - 1)) begin
                seq_d.active = 1'b0;
                seq_d.cnt    = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + CNT_W'(1);
            end
        end else if (fire) begin
            seq_d.active = 1'b1;
            seq_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pulse    = seq_q.active && ((seq_q.cnt == CNT_W'(0)) || (seq_q.cnt == CNT_W'(2)));
    assign finished = seq_q.active && (seq_q.cnt == CNT_W'(SEQ_LEN - 1));
endmodule

// File: rtl/pba_pair_check.sv
module pba_pair_check #(
    parameter int PAIRS = 5
) (
    input  logic [2*PAIRS-1:0] word,
    output logic               slave_zero,
    output logic               dup
);
    logic [PAIRS-1:0] hit;

    assign hit[0] = 1'b0;

    generate
        for (genvar k = 1; k < PAIRS; k++) begin : g_pair
            assign hit[k] = (word[2*k +: 2] == word[1:0]);
        end
    endgenerate

    assign slave_zero = (word[1:0] == 2'b00);
    assign dup        = !slave_zero && (|hit);
endmodule

// File: rtl/pba_aligner.sv
module pba_aligner
    import pba_pkg::*;
#(
    parameter int PAIRS       = 5,
    parameter int STAB_CYCLES = 64,
    parameter int GAP_CYCLES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2*PAIRS-1:0] rx_word,
    output logic               master_slip,
    output logic               slave_slip,
    output logic               done
);
    localparam int CW = $clog2(PAIRS + 1);

    typedef struct packed {
        pba_state_e    state;
        logic          both;
        logic [CW-1:0] samples;
        logic [CW-1:0] mslips;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic fire;
    logic expired;
    logic seq_pulse;
    logic seq_finished;
    logic slave_zero;
    logic dup;

    pba_stab_timer #(.CYCLES(STAB_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.state == ST_WAIT),
        .expired (expired)
    );

    pba_slip_seq #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .pulse    (seq_pulse),
        .finished (seq_finished)
    );

    pba_pair_check #(.PAIRS(PAIRS)) u_pairs (
        .word       (rx_word),
        .slave_zero (slave_zero),
        .dup        (dup)
    );

    always_comb begin
        ctl_d = ctl_q;
        fire  = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state   = ST_WAIT;
                    ctl_d.both    = 1'b1;
                    ctl_d.samples = '0;
                    ctl_d.mslips  = '0;
                end
            end
            ST_WAIT: begin
                if (expired) begin
                    if (ctl_q.both && slave_zero) begin
                        if (ctl_q.samples == CW'(PAIRS - 1)) begin
                            ctl_d.state = ST_DONE;
                        end else begin
                            ctl_d.samples = ctl_q.samples + CW'(1);
                            ctl_d.state   = ST_SLIP;
                            fire          = 1'b1;
                        end
                    end else if (dup && (ctl_q.mslips < CW'(PAIRS))) begin
                        ctl_d.both   = 1'b0;
                        ctl_d.mslips = ctl_q.mslips + CW'(1);
                        ctl_d.state  = ST_SLIP;
                        fire         = 1'b1;
                    end else begin
                        ctl_d.state = ST_DONE;
                    end
                end
            end
            ST_SLIP: begin
                if (seq_finished) ctl_d.state = ST_WAIT;
            end
            ST_DONE: begin
                ctl_d.state = ST_DONE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.both    <= 1'b1;
            ctl_q.samples <= '0;
            ctl_q.mslips  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign master_slip = seq_pulse;
    assign slave_slip  = seq_pulse && ctl_q.both;
    assign done        = (ctl_q.state == ST_DONE);
endmodule

// File: rtl/pba_aligner_chk.sv
module pba_aligner_chk #(
    parameter int STAB_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic master_slip,
    input logic slave_slip,
    input logic done
);
    logic        started_q;
    logic        solo_q;
    logic [15:0] quiet_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            solo_q    <= 1'b0;
            quiet_q   <= '0;
        end else begin
            started_q <= started_q | start;
            solo_q    <= solo_q | (master_slip & !slave_slip);
            if (master_slip)              quiet_q <= '0;
            else if (quiet_q != 16'hFFFF) quiet_q <= quiet_q + 16'd1;
        end
    end

    AST_NO_EARLY_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> (!master_slip && !slave_slip && !done)); // R1
    AST_PULSE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        master_slip |=> !master_slip); // R2
    AST_SLAVE_WITH_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        slave_slip |-> master_slip); // R3
    AST_SOLO_KEEPS_SLAVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        solo_q |-> !slave_slip); // R5
    AST_SETTLE_BEFORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (master_slip && (quiet_q != 16'd1)) |-> (quiet_q >= 16'(STAB_CYCLES))); // R7
    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!master_slip && !slave_slip)); // R8
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R10
endmodule

bind pba_aligner pba_aligner_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .master_slip (master_slip),
    .slave_slip  (slave_slip),
    .done        (done)
);

// File: tb/pba_aligner_bench.sv
`timescale 1ns/1ps
module pba_aligner_bench;
    localparam int PAIRS = 5;
    localparam int W     = 2 * PAIRS;
    localparam int STAB  = 64;
    localparam int GAP   = 2;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] rx    = '0;
    logic         m_slip, s_slip, dn;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [2:0] expq[$];
    int exp_joint, exp_master;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    pba_aligner #(.PAIRS(PAIRS), .STAB_CYCLES(STAB), .GAP_CYCLES(GAP)) u_pba_aligner (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_word(rx),
        .master_slip(m_slip), .slave_slip(s_slip), .done(dn)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [W-1:0] rotr(input logic [W-1:0] p, input int off);
        int o = off % W;
        if (o == 0) return p;
        return (p >> o) | (p << (W - o));
    endfunction

    function automatic logic [W-1:0] lane_word(input logic [W-1:0] pat, input int mo, input int so);
        logic [W-1:0] mv, sv;
        mv = rotr(pat, mo);
        sv = rotr(pat, so);
        return {mv[W-1:2], sv[1:0]};
    endfunction

    task automatic push_step(input bit joint);
        expq.push_back(joint ? 3'b110 : 3'b100);
        expq.push_back(3'b000);
        expq.push_back(joint ? 3'b110 : 3'b100);
        expq.push_back(3'b000);
        repeat (GAP) expq.push_back(3'b000);
    endtask

    task automatic build(input logic [W-1:0] pat, input int mo0, input int so0);
        int mo = mo0, so = so0, samples = 0, ms = 0;
        bit solo = 0, fin = 0, dupl;
        logic [W-1:0] w;
        expq.delete();
        exp_joint = 0;
        exp_master = 0;
        while (!fin) begin
            repeat (STAB) expq.push_back(3'b000);
            w = lane_word(pat, mo, so);
            dupl = 0;
            for (int k = 1; k < PAIRS; k++)
                if (w[1:0] != 2'b00 && w[2*k +: 2] == w[1:0]) dupl = 1;
            if (!solo && w[1:0] == 2'b00) begin
                samples++;
                if (samples == PAIRS) fin = 1;
                else begin
                    push_step(1); mo += 2; so += 2; exp_joint++;
                end
            end else begin
                solo = 1;
                if (dupl && ms < PAIRS) begin
                    ms++; push_step(0); mo += 2; exp_master++;
                end else fin = 1;
            end
        end
        repeat (20) expq.push_back(3'b001);
    endtask

    task automatic run_case(input logic [W-1:0] pat, input int mo, input int so, input string req);
        int bm = mo, bs = so, am = 0, as_ = 0;
        logic [2:0] e;
        string tag;
        rst_n = 1'b0;
        start = 1'b0;
        rx = lane_word(pat, bm, bs);
        repeat (3) @(negedge clk);
        chk({m_slip, s_slip, dn} == 3'b000, "R1", {m_slip, s_slip, dn}, 0);
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk({m_slip, s_slip, dn} == 3'b000, "R1", {m_slip, s_slip, dn}, 0);
        end
        build(pat, mo, so);
        start = 1'b1;
        while (expq.size() > 0) begin
            @(negedge clk);
            e = expq.pop_front();
            case (e)
                3'b110:  tag = "R3";
                3'b100:  tag = "R5";
                3'b001:  tag = "R8";
                default: tag = "R2/R7";
            endcase
            chk({m_slip, s_slip, dn} == e, tag, {m_slip, s_slip, dn}, e);
            if (m_slip) begin am++; bm++; end
            if (s_slip) begin as_++; bs++; end
            rx = lane_word(pat, bm, bs);
        end
        chk(as_ == 2 * exp_joint, req, as_, 2 * exp_joint);
        chk(am == 2 * (exp_joint + exp_master), req, am, 2 * (exp_joint + exp_master));
        start = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk({m_slip, s_slip, dn} == 3'b001, "R10", {m_slip, s_slip, dn}, 1);
        end
        start = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk({m_slip, s_slip, dn} == 3'b001, "R10", {m_slip, s_slip, dn}, 1);
        end
        start = 1'b0;
    endtask

    initial begin
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        run_case(10'h001, 0, 0, "R8");   // aligned on the first sample
        run_case(10'h010, 0, 0, "R4");   // two joint steps, then aligned
        run_case(10'h018, 0, 0, "R4");   // double-bit pattern
        run_case(10'h001, 8, 0, "R6");   // one master step
        run_case(10'h001, 2, 0, "R6");   // four master steps
        run_case(10'h030, 0, 4, "R6");   // master step on the very first sample
        run_case(10'h300, 4, 0, "R6");   // phase handoff after joint steps
        run_case(10'h000, 0, 0, "R9");   // joint budget used up
        run_case(10'h155, 0, 0, "R9");   // master budget used up
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule